// File: doc/BRIEF.md
# DMA Configuration and Interrupt Gating Register

This block holds the control word of a USB peripheral's DMA engine. A host microcontroller writes a whole byte in one command cycle and can read the current value back at any time. The low bits drive the engine:

- two bits select the burst length;
- one bit turns DMA on;
- one bit picks the transfer direction;
- one bit chooses whether the enable survives an end-of-transfer event.

The upper bits configure the interrupt line. One bit selects the interrupt pin mode, and one bit per bulk endpoint masks that endpoint's request.

When auto-reload is off, an end-of-transfer pulse from the DMA engine clears the enable on its own. Firmware must then write the register again before the next transfer.

All endpoint requests are folded into a single interrupt output. Endpoint requests pass only when enabled, and the non-gated core sources always pass. In level mode the output follows the combined request. In pulse mode it gives a one-cycle strobe on each rising edge of that request.

Top module: `dma_cfg_reg`

## Requirements
- R1: While rst_ni is low and after its release, the register reads 8'h00, and dma_en_o, dma_dir_o, burst_o, auto_reload_o and irq_o are all 0.
- R2: A cycle with wr_en_i high loads wr_data_i into the register, and cfg_o shows it from the next clock edge on. Without a write or an end-of-transfer pulse the value is held.
- R3: The field outputs follow the register:
  - burst_o is bits 1:0;
  - dma_en_o is bit 2;
  - dma_dir_o is bit 3 (1 means IN-token, 0 means OUT-token);
  - auto_reload_o is bit 4.
- R4: An eot_i pulse while bit 4 is 0 clears bit 2 at the next edge and leaves every other bit unchanged.
- R5: An eot_i pulse while bit 4 is 1 leaves the whole register unchanged, so the enable stays set.
- R6: With bit 5 = 0 (level mode), irq_o is the OR of every core_irq_i bit and of each ep_irq_i[k] that is enabled by register bit 6+k. Bit 6 gates endpoint 4, which is ep_irq_i[0], and bit 7 gates endpoint 5, which is ep_irq_i[1].
- R7: When wr_en_i and eot_i are high in the same cycle, the register takes wr_data_i unchanged.
- R8: With bit 5 = 1 (pulse mode), irq_o is high for exactly one cycle when the combined request of R6 rises, and is low while the request stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write command strobe |
| wr_data_i | input | 8 | Value to write |
| eot_i | input | 1 | End-of-transfer pulse from the DMA engine |
| ep_irq_i | input | 2 | Gated bulk endpoint interrupt requests |
| core_irq_i | input | 4 | Non-gated interrupt sources |
| cfg_o | output | 8 | Register readback |
| burst_o | output | 2 | DMA burst length select |
| dma_en_o | output | 1 | DMA enable |
| dma_dir_o | output | 1 | DMA direction, 1 means IN |
| auto_reload_o | output | 1 | Auto-reload setting |
| irq_o | output | 1 | Shared interrupt output |

## Verification
The bench builds the block with its defaults: two gated endpoints and four core sources, which gives the 8-bit register layout. With that layout, every field position, both endpoint masks and the pass-through of core sources can be reached through single-byte writes. Register contents are predicted by a bench model and checked through a scoreboard. That covers the end-of-transfer clear with auto-reload off and on, and the collision between a write and an end-of-transfer pulse. Interrupt gating is checked in both pin modes, including the single-cycle strobe in pulse mode.

// File: rtl/dma_cfg_pkg.sv
package dma_cfg_pkg;
  localparam int BURST_LSB   = 0;
  localparam int EN_BIT      = 2;
  localparam int DIR_BIT     = 3;
  localparam int RELOAD_BIT  = 4;
  localparam int PINMODE_BIT = 5;
  localparam int EP_EN_LSB   = 6;
endpackage

// File: rtl/dma_cfg_store.sv
module dma_cfg_store
  import dma_cfg_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             eot_i,
  output logic [REG_W-1:0] q_o
);
  logic [REG_W-1:0] q_d;

  always_comb begin
    q_d = q_o;
    if (wr_en_i) begin
      q_d = wr_data_i;                      // write beats eot
    end else if (eot_i && !q_o[RELOAD_BIT]) begin
      q_d[EN_BIT] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= q_d;
  end
endmodule

// File: rtl/dma_irq_gate.sv
module dma_irq_gate #(
  parameter int N_GATED = 2,
  parameter int N_CORE  = 4
) (
  input  logic [N_GATED-1:0] ep_irq_i,
  input  logic [N_GATED-1:0] ep_en_i,
  input  logic [N_CORE-1:0]  core_irq_i,
  output logic               req_o
);
  logic [N_GATED-1:0] masked;

  for (genvar k = 0; k < N_GATED; k++) begin : g_mask
    assign masked[k] = ep_irq_i[k] & ep_en_i[k];
  end

  assign req_o = (|masked) | (|core_irq_i);
endmodule

// File: rtl/dma_irq_shaper.sv
module dma_irq_shaper (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_mode_i,
  input  logic req_i,
  output logic irq_o
);
  logic req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= req_i;
  end

  assign irq_o = pulse_mode_i ? (req_i & ~req_q) : req_i;
endmodule

// File: rtl/dma_cfg_reg.sv
module dma_cfg_reg
  import dma_cfg_pkg::*;
#(
  parameter int N_GATED = 2,
  parameter int N_CORE  = 4,
  localparam int REG_W  = EP_EN_LSB + N_GATED
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [REG_W-1:0]   wr_data_i,
  input  logic               eot_i,
  input  logic [N_GATED-1:0] ep_irq_i,
  input  logic [N_CORE-1:0]  core_irq_i,
  output logic [REG_W-1:0]   cfg_o,
  output logic [1:0]         burst_o,
  output logic               dma_en_o,
  output logic               dma_dir_o,
  output logic               auto_reload_o,
  output logic               irq_o
);
  logic [REG_W-1:0] cfg_q;
  logic             comb_req;

  dma_cfg_store #(.REG_W(REG_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .eot_i     (eot_i),
    .q_o       (cfg_q)
  );

  dma_irq_gate #(.N_GATED(N_GATED), .N_CORE(N_CORE)) u_gate (
    .ep_irq_i   (ep_irq_i),
    .ep_en_i    (cfg_q[REG_W-1:EP_EN_LSB]),
    .core_irq_i (core_irq_i),
    .req_o      (comb_req)
  );

  dma_irq_shaper u_shaper (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pulse_mode_i (cfg_q[PINMODE_BIT]),
    .req_i        (comb_req),
    .irq_o        (irq_o)
  );

  assign cfg_o         = cfg_q;
  assign burst_o       = cfg_q[BURST_LSB+1:BURST_LSB];
  assign dma_en_o      = cfg_q[EN_BIT];
  assign dma_dir_o     = cfg_q[DIR_BIT];
  assign auto_reload_o = cfg_q[RELOAD_BIT];
endmodule

// File: rtl/dma_cfg_chk.sv
module dma_cfg_chk
  import dma_cfg_pkg::*;
#(
  parameter int N_GATED = 2,
  parameter int N_CORE  = 4,
  localparam int REG_W  = EP_EN_LSB + N_GATED
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [REG_W-1:0]   wr_data_i,
  input logic               eot_i,
  input logic [N_GATED-1:0] ep_irq_i,
  input logic [N_CORE-1:0]  core_irq_i,
  input logic [REG_W-1:0]   cfg_o,
  input logic               dma_en_o,
  input logic               irq_o
);
  logic [N_GATED-1:0] ep_live;
  assign ep_live = ep_irq_i & cfg_o[REG_W-1:EP_EN_LSB];

  p_reset_zero_r1: assert property (@(posedge clk_i) !rst_ni |=> cfg_o == '0);

  p_write_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !eot_i |=> cfg_o == $past(wr_data_i));

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i && !eot_i |=> $stable(cfg_o));

  p_eot_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i && eot_i && !cfg_o[RELOAD_BIT] |=> !dma_en_o);

  p_reload_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i && eot_i && cfg_o[RELOAD_BIT] |=> $stable(cfg_o));

  p_collide_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && eot_i |=> cfg_o == $past(wr_data_i));

  p_masked_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ep_live == '0) && (core_irq_i == '0) |-> !irq_o);

  p_single_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_o[PINMODE_BIT] && $stable(cfg_o) && irq_o |=> !irq_o);
endmodule

bind dma_cfg_reg dma_cfg_chk #(.N_GATED(N_GATED), .N_CORE(N_CORE)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_data_i  (wr_data_i),
  .eot_i      (eot_i),
  .ep_irq_i   (ep_irq_i),
  .core_irq_i (core_irq_i),
  .cfg_o      (cfg_o),
  .dma_en_o   (dma_en_o),
  .irq_o      (irq_o)
);

// File: tb/tb_dma_cfg_reg.sv
`timescale 1ns/1ps
module tb_dma_cfg_reg;
  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       wr_en = 0;
  logic [7:0] wr_data = '0;
  logic       eot = 0;
  logic [1:0] ep_irq = '0;
  logic [3:0] core_irq = '0;
  logic [7:0] cfg;
  logic [1:0] burst;
  logic       dma_en, dma_dir, auto_reload, irq;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] model = '0;
  item_t sb_q[$];

  always #5 clk = ~clk;

  dma_cfg_reg dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .eot_i(eot), .ep_irq_i(ep_irq), .core_irq_i(core_irq), .cfg_o(cfg),
    .burst_o(burst), .dma_en_o(dma_en), .dma_dir_o(dma_dir),
    .auto_reload_o(auto_reload), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // driver: one command cycle, expected readback pushed to scoreboard
  task automatic step(input logic w, input logic [7:0] d, input logic e, input string tag);
    item_t it;
    @(negedge clk);
    wr_en = w; wr_data = d; eot = e;
    if (w) model = d;
    else if (e && !model[4]) model[2] = 1'b0;
    @(posedge clk);
    it.exp = model; it.tag = tag;
    sb_q.push_back(it);
    #1 wr_en = 0; eot = 0;
  endtask

  // monitor
  always @(posedge clk) begin
    #2;
    while (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      check(it.tag, {24'h0, cfg}, {24'h0, it.exp});
    end
  end

  task automatic set_irq(input logic [1:0] ep, input logic [3:0] core);
    @(negedge clk);
    ep_irq = ep; core_irq = core;
    #1;
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 cfg in reset", {24'h0, cfg}, 0);
    rst_n = 1;
    @(posedge clk); #1;
    check("R1 cfg after reset", {24'h0, cfg}, 0);
    check("R1 outputs after reset", {26'h0, burst, dma_en, dma_dir, auto_reload, irq}, 0);

    step(1, 8'h1F, 0, "R2 write 1F");
    #3;
    check("R3 burst", {30'h0, burst}, 3);
    check("R3 enable", {31'h0, dma_en}, 1);
    check("R3 dir IN", {31'h0, dma_dir}, 1);
    check("R3 auto reload", {31'h0, auto_reload}, 1);
    step(0, 8'h00, 0, "R2 hold");
    step(0, 8'h00, 1, "R5 eot with reload");
    #3 check("R5 enable kept", {31'h0, dma_en}, 1);

    step(1, 8'h07, 0, "R2 write 07");
    #3 check("R3 dir OUT", {31'h0, dma_dir}, 0);
    step(0, 8'h00, 1, "R4 eot clears enable");
    #3 check("R4 enable off", {31'h0, dma_en}, 0);
    step(0, 8'h00, 1, "R4 eot while off");

    step(1, 8'h0F, 0, "R2 write 0F");
    step(1, 8'h0C, 1, "R7 write with eot");
    #3 check("R7 enable from write", {31'h0, dma_en}, 1);
    step(1, 8'hA5, 1, "R7 write with eot A5");

    // level mode gating
    step(1, 8'h40, 0, "R2 write 40");
    set_irq(2'b01, 4'h0); check("R6 ep4 enabled", {31'h0, irq}, 1);
    set_irq(2'b10, 4'h0); check("R6 ep5 masked", {31'h0, irq}, 0);
    set_irq(2'b10, 4'h4); check("R6 core passes", {31'h0, irq}, 1);
    set_irq(2'b00, 4'h0);
    step(1, 8'h80, 0, "R2 write 80");
    set_irq(2'b01, 4'h0); check("R6 ep4 masked", {31'h0, irq}, 0);
    set_irq(2'b10, 4'h0); check("R6 ep5 enabled", {31'h0, irq}, 1);
    set_irq(2'b00, 4'h0); check("R6 idle", {31'h0, irq}, 0);

    // pulse mode
    step(1, 8'hE0, 0, "R2 write E0");
    set_irq(2'b00, 4'h0);
    set_irq(2'b01, 4'h0); check("R8 pulse rise", {31'h0, irq}, 1);
    @(posedge clk); #2 check("R8 pulse ends", {31'h0, irq}, 0);
    set_irq(2'b11, 4'h0); check("R8 held request low", {31'h0, irq}, 0);
    set_irq(2'b00, 4'h0); check("R8 request drop", {31'h0, irq}, 0);
    set_irq(2'b00, 4'h1); check("R8 core rise pulses", {31'h0, irq}, 1);
    @(posedge clk); #2 check("R8 core pulse ends", {31'h0, irq}, 0);
    set_irq(2'b00, 4'h0);

    repeat (3) @(posedge clk);
    #3 check("R2 queue drained", sb_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule